// File: doc/BRIEF.md
# Machine-Cycle Strobe Sequencer

This block sets the machine-cycle timing of an 8-bit controller and drives the strobes for its external memory bus. It halves the oscillator clock with a phase flip-flop, so the duty cycle of the input clock does not matter. Every two oscillator periods it advances a state counter that runs from 1 to 6. One machine cycle therefore lasts twelve oscillator periods, split into twelve slots, S1P1 through S6P2. From the slot position it drives these outputs:
- an address-latch pulse, `aleOut`, active high;
- an active-low program-read strobe, `psenN`;
- active-low data read and data write strobes, `rdN` and `wrN`.

The surrounding core gives three inputs:
- `fetchExternal`, high when code comes from external program memory;
- `xferReq`, high to request an external data transfer;
- `xferWrite`, which gives the direction of that transfer.

The block samples these inputs once per machine cycle, on the edge that moves from S6P2 to S1P1, and holds them for the whole cycle that follows. In a cycle with a data transfer, the second address-latch pulse and both program-read strobes are dropped. The read or write strobe is held low in their place.

Top module: `busStrobeGen`

## Requirements
- R1: `phaseNum` alternates on every oscillator clock (0 = P1, 1 = P2). `stateNum` holds for two clocks, counts 1 to 6 and wraps from 6 back to 1, so one machine cycle spans 12 clocks. Slot index = 2*(stateNum-1)+phaseNum.
- R2: In a cycle without a data transfer, `aleOut` is high in slots 1, 2, 7 and 8 (S1P2, S2P1, S4P2, S5P1) and low otherwise. This gives two pulses per 12 clocks.
- R3: In a data-transfer cycle, `aleOut` is high only in slots 1 and 2. The pulse in slots 7 and 8 is suppressed.
- R4: In a cycle with `fetchExternal` sampled high and no data transfer, `psenN` is low in slots 3 to 5 and 9 to 11, and high otherwise.
- R5: In a cycle with `fetchExternal` sampled low, `psenN` stays high for the whole cycle.
- R6: In a data-transfer cycle, `psenN` stays high. The selected strobe is low in slots 3 to 11 and high in slots 0 to 2: `rdN` when `xferWrite` was sampled 0, `wrN` when it was sampled 1.
- R7: `rdN` and `wrN` are never low together. Both stay high in any cycle without a data transfer.
- R8: `fetchExternal`, `xferReq` and `xferWrite` are sampled only on the clock edge that leaves slot 11. Changing them at any other time has no effect on the current cycle's strobes.
- R9: While `rst` is high, the block shows `stateNum`=1, `phaseNum`=0, `aleOut`=0 and `psenN`=`rdN`=`wrN`=1. The first cycle after reset runs as an internal-fetch cycle without a data transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Oscillator clock |
| rst | input | 1 | Asynchronous reset, active high |
| fetchExternal | input | 1 | 1 = fetch code from external program memory |
| xferReq | input | 1 | Request an external data transfer in the next machine cycle |
| xferWrite | input | 1 | Transfer direction: 1 = write, 0 = read |
| aleOut | output | 1 | Address-latch pulse, active high |
| psenN | output | 1 | Program-read strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| stateNum | output | 3 | Current state, 1 to 6 |
| phaseNum | output | 1 | Current phase, 0 = P1, 1 = P2 |

## Verification
All outputs are registers that change on the same clock edge as the slot counter. The strobes seen in slot k therefore belong to slot k, with no lag. An input change takes effect first in the cycle that starts after the next exit from slot 11. That can be up to twelve clocks later, which is what R8 describes. The bench keeps its own slot and mode model, advances it on each rising edge and latches the inputs only on the wrap edge. It compares every output at the following falling edge. The reset values are checked one time unit after `rst` rises, since the reset acts at once.

// File: rtl/busTimingPkg.sv
package busTimingPkg;
  localparam int PHASES  = 2;
  localparam int STATES  = 6;
  localparam int SLOTS   = STATES * PHASES;
  localparam int STATE_W = $clog2(STATES + 1);
  localparam int SLOT_W  = $clog2(SLOTS);

  // slot windows, slot = 2*(state-1)+phase
  localparam int ALE_A_LO   = 1;
  localparam int ALE_A_HI   = 2;
  localparam int ALE_B_LO   = 7;
  localparam int ALE_B_HI   = 8;
  localparam int FETCH_A_LO = 3;
  localparam int FETCH_A_HI = 5;
  localparam int FETCH_B_LO = 9;
  localparam int FETCH_B_HI = 11;
  localparam int DATA_LO    = 3;
  localparam int DATA_HI    = 11;

  typedef struct packed {
    logic aleA;
    logic aleB;
    logic fetchA;
    logic fetchB;
    logic dataWin;
    logic cycleWrap;
  } slotStrobes_t;
endpackage

// File: rtl/busTimingCtrl.sv
module busTimingCtrl
  import busTimingPkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  output logic [STATE_W-1:0]   stateNum,
  output logic                 phaseNum,
  output slotStrobes_t         nextStrobes
);
  logic               phaseQ;
  logic [STATE_W-1:0] stateQ;
  logic               nextPhase;
  logic [STATE_W-1:0] nextState;
  logic [STATE_W-1:0] nextStateM1;
  logic [SLOT_W-1:0]  nextSlot;

  function automatic logic inWin(input logic [SLOT_W-1:0] s, input int lo, input int hi);
    return (int'(s) >= lo) && (int'(s) <= hi);
  endfunction

  always_comb begin
    nextPhase = ~phaseQ;
    if (phaseQ) begin
      if (stateQ == STATE_W'(STATES)) nextState = STATE_W'(1);
      else                            nextState = stateQ + STATE_W'(1);
    end else begin
      nextState = stateQ;
    end
    nextStateM1 = nextState - STATE_W'(1);
    nextSlot    = SLOT_W'({nextStateM1, nextPhase});
  end

  always_comb begin
    nextStrobes.aleA      = inWin(nextSlot, ALE_A_LO, ALE_A_HI);
    nextStrobes.aleB      = inWin(nextSlot, ALE_B_LO, ALE_B_HI);
    nextStrobes.fetchA    = inWin(nextSlot, FETCH_A_LO, FETCH_A_HI);
    nextStrobes.fetchB    = inWin(nextSlot, FETCH_B_LO, FETCH_B_HI);
    nextStrobes.dataWin   = inWin(nextSlot, DATA_LO, DATA_HI);
    nextStrobes.cycleWrap = (nextSlot == '0);
  end

  // divide-by-two phase flop and state counter
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phaseQ <= 1'b0;
      stateQ <= STATE_W'(1);
    end else begin
      phaseQ <= nextPhase;
      stateQ <= nextState;
    end
  end

  assign stateNum = stateQ;
  assign phaseNum = phaseQ;

  p_phase_rise_r1: assert property (@(posedge clk) disable iff (rst) !phaseQ |=> phaseQ);
  p_phase_fall_r1: assert property (@(posedge clk) disable iff (rst) phaseQ |=> !phaseQ);
  p_state_hold_r1: assert property (@(posedge clk) disable iff (rst) !phaseQ |=> $stable(stateQ));
  p_state_wrap_r1: assert property (@(posedge clk) disable iff (rst)
                     (phaseQ && stateQ == STATE_W'(STATES)) |=> stateQ == STATE_W'(1));
  p_state_range_r1: assert property (@(posedge clk) disable iff (rst)
                     stateQ >= STATE_W'(1) && stateQ <= STATE_W'(STATES));
endmodule

// File: rtl/busTimingPath.sv
module busTimingPath
  import busTimingPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         fetchExternal,
  input  logic         xferReq,
  input  logic         xferWrite,
  input  slotStrobes_t nextStrobes,
  output logic         aleOut,
  output logic         psenN,
  output logic         rdN,
  output logic         wrN
);
  logic extMode, dataMode, writeMode;
  logic nextExt, nextData, nextWrite;
  logic aleD, psenD, rdD, wrD;

  always_comb begin
    nextExt   = nextStrobes.cycleWrap ? fetchExternal : extMode;
    nextData  = nextStrobes.cycleWrap ? xferReq       : dataMode;
    nextWrite = nextStrobes.cycleWrap ? xferWrite     : writeMode;
    aleD  = nextStrobes.aleA | (nextStrobes.aleB & ~nextData);
    psenD = ~(nextExt & ~nextData & (nextStrobes.fetchA | nextStrobes.fetchB));
    rdD   = ~(nextData & ~nextWrite & nextStrobes.dataWin);
    wrD   = ~(nextData &  nextWrite & nextStrobes.dataWin);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      extMode   <= 1'b0;
      dataMode  <= 1'b0;
      writeMode <= 1'b0;
      aleOut    <= 1'b0;
      psenN     <= 1'b1;
      rdN       <= 1'b1;
      wrN       <= 1'b1;
    end else begin
      extMode   <= nextExt;
      dataMode  <= nextData;
      writeMode <= nextWrite;
      aleOut    <= aleD;
      psenN     <= psenD;
      rdN       <= rdD;
      wrN       <= wrD;
    end
  end

  p_rdwr_excl_r7: assert property (@(posedge clk) disable iff (rst) rdN || wrN);
  p_no_strobe_idle_r7: assert property (@(posedge clk) disable iff (rst) !dataMode |-> (rdN && wrN));
  p_psen_quiet_data_r6: assert property (@(posedge clk) disable iff (rst) dataMode |-> psenN);
  p_psen_internal_r5: assert property (@(posedge clk) disable iff (rst) !extMode |-> psenN);
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
                    !nextStrobes.cycleWrap |=> ($stable(dataMode) && $stable(extMode) && $stable(writeMode)));
  p_ale_data_r3: assert property (@(posedge clk) disable iff (rst)
                    (aleOut && dataMode) |-> rdN && wrN);
endmodule

// File: rtl/busStrobeGen.sv
module busStrobeGen
  import busTimingPkg::*;
(
  input  logic         oscClk,
  input  logic         rst,
  input  logic         fetchExternal,
  input  logic         xferReq,
  input  logic         xferWrite,
  output logic         aleOut,
  output logic         psenN,
  output logic         rdN,
  output logic         wrN,
  output logic [2:0]   stateNum,
  output logic         phaseNum
);
  slotStrobes_t       strobeBus;
  logic [STATE_W-1:0] stateInt;

  busTimingCtrl ctrl_i (
    .clk         (oscClk),
    .rst         (rst),
    .stateNum    (stateInt),
    .phaseNum    (phaseNum),
    .nextStrobes (strobeBus)
  );

  busTimingPath path_i (
    .clk           (oscClk),
    .rst           (rst),
    .fetchExternal (fetchExternal),
    .xferReq       (xferReq),
    .xferWrite     (xferWrite),
    .nextStrobes   (strobeBus),
    .aleOut        (aleOut),
    .psenN         (psenN),
    .rdN           (rdN),
    .wrN           (wrN)
  );

  assign stateNum = 3'(stateInt);
endmodule

// File: tb/busStrobeGen_tb.sv
module busStrobeGen_tb_top;
  logic oscClk = 1'b0;
  logic rst;
  logic fetchExternal, xferReq, xferWrite;
  logic aleOut, psenN, rdN, wrN, phaseNum;
  logic [2:0] stateNum;

  int checks = 0;
  int errors = 0;
  int modelSlot = 0;
  logic mExt = 0, mData = 0, mWrite = 0;
  string ctx = "";

  always #10 oscClk = ~oscClk;

  busStrobeGen dut_i (
    .oscClk(oscClk), .rst(rst), .fetchExternal(fetchExternal), .xferReq(xferReq),
    .xferWrite(xferWrite), .aleOut(aleOut), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .stateNum(stateNum), .phaseNum(phaseNum)
  );

  function automatic logic expAle(int s, logic d);
    return (s == 1 || s == 2) || (!d && (s == 7 || s == 8));
  endfunction
  function automatic logic expPsen(int s, logic e, logic d);
    return !(e && !d && ((s >= 3 && s <= 5) || (s >= 9 && s <= 11)));
  endfunction
  function automatic logic expRd(int s, logic d, logic w);
    return !(d && !w && s >= 3);
  endfunction
  function automatic logic expWr(int s, logic d, logic w);
    return !(d && w && s >= 3);
  endfunction

  task automatic cmp(string tag, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s %s slot=%0d: actual=%0d expected=%0d", tag, ctx, what, modelSlot, act, expv);
    end
  endtask

  task automatic checkOutputs();
    cmp("R1", int'(stateNum), modelSlot / 2 + 1, "stateNum");
    cmp("R1", int'(phaseNum), modelSlot % 2, "phaseNum");
    cmp(mData ? "R3" : "R2", int'(aleOut), int'(expAle(modelSlot, mData)), "aleOut");
    cmp(mData ? "R6" : (mExt ? "R4" : "R5"), int'(psenN), int'(expPsen(modelSlot, mExt, mData)), "psenN");
    cmp(mData ? "R6" : "R7", int'(rdN), int'(expRd(modelSlot, mData, mWrite)), "rdN");
    cmp(mData ? "R6" : "R7", int'(wrN), int'(expWr(modelSlot, mData, mWrite)), "wrN");
  endtask

  task automatic stepClock();
    @(posedge oscClk);
    if (modelSlot == 11) begin
      modelSlot = 0;
      mExt = fetchExternal; mData = xferReq; mWrite = xferWrite;
    end else begin
      modelSlot++;
    end
    @(negedge oscClk);
    checkOutputs();
  endtask

  // run one machine cycle; the wanted mode is driven before the wrap edge
  task automatic runCycle(logic e, logic d, logic w, logic jitter);
    for (int i = 0; i < 12; i++) begin
      if (modelSlot == 11) begin
        fetchExternal = e; xferReq = d; xferWrite = w;
      end else if (jitter) begin
        fetchExternal = 1'($urandom); xferReq = 1'($urandom); xferWrite = 1'($urandom);
      end
      stepClock();
    end
  endtask

  task automatic checkReset();
    cmp("R9", int'(stateNum), 1, "reset stateNum");
    cmp("R9", int'(phaseNum), 0, "reset phaseNum");
    cmp("R9", int'(aleOut), 0, "reset aleOut");
    cmp("R9", int'(psenN), 1, "reset psenN");
    cmp("R9", int'(rdN), 1, "reset rdN");
    cmp("R9", int'(wrN), 1, "reset wrN");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240);
    rst = 1'b1; fetchExternal = 1'b1; xferReq = 1'b0; xferWrite = 1'b0;
    repeat (3) @(negedge oscClk);
    ctx = "R9 power-up";
    checkReset();
    rst = 1'b0;
    modelSlot = 0; mExt = 0; mData = 0; mWrite = 0;

    // first cycle after reset: internal, no transfer (R9, R5)
    ctx = "R9 first cycle";
    runCycle(1'b1, 1'b0, 1'b0, 1'b0);
    ctx = "R2 R4 external fetch";
    runCycle(1'b0, 1'b0, 1'b0, 1'b0);
    ctx = "R5 internal fetch";
    runCycle(1'b1, 1'b1, 1'b0, 1'b0);
    ctx = "R3 R6 read";
    runCycle(1'b1, 1'b1, 1'b1, 1'b0);
    ctx = "R6 R7 write";
    runCycle(1'b1, 1'b0, 1'b0, 1'b0);
    ctx = "R7 back to fetch";
    runCycle(1'b0, 1'b1, 1'b1, 1'b0);

    // constrained random modes, inputs toggled mid-cycle (R8)
    ctx = "R8 random";
    for (int c = 0; c < 300; c++)
      runCycle(1'($urandom), ($urandom % 3) == 0, 1'($urandom), 1'b1);

    // reset in the middle of a cycle (R9)
    repeat (5) begin
      fetchExternal = 1'b0; xferReq = 1'b1;
      stepClock();
    end
    rst = 1'b1;
    #1;
    ctx = "R9 mid-cycle reset";
    checkReset();
    @(negedge oscClk);
    checkReset();
    rst = 1'b0;
    modelSlot = 0; mExt = 0; mData = 0; mWrite = 0;
    ctx = "R9 after reset";
    runCycle(1'b1, 1'b1, 1'b0, 1'b0);
    ctx = "R6 read after reset";
    runCycle(1'b1, 1'b0, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule